// File: doc/BRIEF.md
# CAN Mailbox Transmit-Pending Controller

This block keeps the per-mailbox transmit-request state for a sixteen-mailbox CAN message buffer. Software reaches it through a 16-bit register port. It raises a mailbox's request bit by writing a one, and it asks for a request to be withdrawn through a separate cancel register. The request flags are also visible as a 32-bit longword split over two halfword offsets. Reading the upper half captures the lower half, so a longword read made as two bus cycles stays coherent.

Internally the block picks one pending mailbox and offers it to a transmit engine. The engine reports each attempt as sent, lost arbitration, or bus error. A sent message drops its request. A failed one is offered again, unless that mailbox forbids retransmission or a cancel is waiting for it. In that case the request drops and the abort-acknowledge bit for the mailbox is raised. The mailbox-empty interrupt flag is raised whenever a request drops.

Top module: `can_txpend`

## Requirements
- R1: Bits 15..1 of the request word at offset 0x022 belong to mailboxes 15..1. Bit 0 has no mailbox behind it, always reads 0, and cannot be set.
- R2: The upper request word at offset 0x020 always reads 0x0000, and writes to it change nothing.
- R3: Writing 1 to a bit of 0x022 sets that mailbox's request if `mbx_is_tx` marks the mailbox as a transmitter. Writing 0, or writing to a mailbox that is not a transmitter, leaves the bit unchanged.
- R4: No CPU write clears a request bit. A request clears only through an engine outcome or a completed cancel.
- R5: An outcome of success (`eng_result` = 2'b00) clears the request for the mailbox in flight. It raises the empty flag (`irq_mbx_empty`, also bit 8 of offset 0x008) and sets no abort-acknowledge bit.
- R6: A failed outcome (2'b01 arbitration lost, 2'b10 bus error) for a mailbox with its `mbx_no_retry` bit at 0 and no cancel waiting keeps the request set, and the mailbox is offered again.
- R7: A failed outcome for a mailbox with its `mbx_no_retry` bit at 1 clears the request. It sets that mailbox's bit in the abort-acknowledge register (offset 0x02A) and raises the empty flag.
- R8: With `prio_by_number` = 0, the offered mailbox is the pending one with the numerically lowest identifier. When identifiers are equal, the higher mailbox number wins. The choice is made again after each failed attempt.
- R9: With `prio_by_number` = 1, the offered mailbox is the highest-numbered pending mailbox.
- R10: Writing 1 to a bit of the cancel register (offset 0x026) for a pending mailbox that is not in flight clears its request, sets its abort-acknowledge bit and raises the empty flag. A cancel for a mailbox that is not pending is ignored.
- R11: A cancel for the mailbox in flight waits for that attempt to end. On success the request clears with no abort acknowledge. On failure the request clears and the abort-acknowledge bit is set.
- R12: A read of 0x022 that is the bus access directly after a read of 0x020 returns the request word as it stood at the 0x020 read. Any other read of 0x022 returns the live value.
- R13: Writing 1 to a bit of 0x02A clears that abort-acknowledge bit. Writing 1 to bit 8 of 0x008 clears the empty flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered, valid the cycle after the read |
| prio_by_number | input | 1 | 0 = identifier priority, 1 = mailbox-number priority |
| mbx_is_tx | input | 16 | Mailbox configured as transmitter |
| mbx_no_retry | input | 16 | Mailbox forbids automatic retransmission |
| mbx_id_flat | input | 176 | Packed 11-bit identifiers, mailbox m at bits m*11 +: 11 |
| offer_valid | output | 1 | A mailbox is offered to the engine |
| offer_mbx | output | 4 | Number of the offered mailbox |
| eng_start | input | 1 | Engine takes the current offer |
| eng_done | input | 1 | Engine reports the end of an attempt |
| eng_result | input | 2 | Outcome: 00 sent, 01 arbitration lost, 10 bus error |
| irq_mbx_empty | output | 1 | Mailbox-empty interrupt flag |

## Verification
The assertions assume that the engine pulses `eng_done` only while an attempt it started is open. They also assume that `eng_start` is raised only while `offer_valid` is high, and that `eng_result` carries one of the three defined codes. The bench's engine model keeps to this. It waits for an offer before pulsing start, finishes each attempt with a single done pulse, and uses only the three codes. Mailbox configuration and identifiers are changed only while no attempt is open.

// File: rtl/tp_pkg.sv
package tp_pkg;
  localparam int DW = 16;
  localparam int AW = 8;

  localparam logic [AW-1:0] OFS_IRQ     = 8'h08;
  localparam logic [AW-1:0] OFS_PEND_HI = 8'h20;
  localparam logic [AW-1:0] OFS_PEND_LO = 8'h22;
  localparam logic [AW-1:0] OFS_CANCEL  = 8'h26;
  localparam logic [AW-1:0] OFS_ABACK   = 8'h2A;

  localparam int IRQ_EMPTY_BIT = 8;

  typedef enum logic [1:0] {
    RES_SENT = 2'b00,
    RES_ARB  = 2'b01,
    RES_ERR  = 2'b10
  } eng_res_t;
endpackage

// File: rtl/tp_bus.sv
module tp_bus
  import tp_pkg::*;
#(
  parameter int NMBX = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  input  logic [NMBX-1:0] pend_q,
  input  logic [NMBX-1:0] cxl_q,
  input  logic [NMBX-1:0] aback_q,
  input  logic            irq_q,
  output logic [NMBX-1:0] set_req,
  output logic [NMBX-1:0] cxl_req,
  output logic [NMBX-1:0] aback_clr,
  output logic            irq_clr,
  output logic [DW-1:0]   bus_rdata
);
  logic            wr_en, rd_en;
  logic [NMBX-1:0] shadow_q;
  logic            armed_q;
  logic [DW-1:0]   rd_mux;

  assign wr_en = bus_sel && bus_wr;
  assign rd_en = bus_sel && !bus_wr;

  assign set_req   = (wr_en && bus_addr == OFS_PEND_LO) ? bus_wdata[NMBX-1:0] : '0;
  assign cxl_req   = (wr_en && bus_addr == OFS_CANCEL)  ? bus_wdata[NMBX-1:0] : '0;
  assign aback_clr = (wr_en && bus_addr == OFS_ABACK)   ? bus_wdata[NMBX-1:0] : '0;
  assign irq_clr   = wr_en && bus_addr == OFS_IRQ && bus_wdata[IRQ_EMPTY_BIT];

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      OFS_PEND_LO: rd_mux = armed_q ? DW'(shadow_q) : DW'(pend_q);
      OFS_CANCEL:  rd_mux = DW'(cxl_q);
      OFS_ABACK:   rd_mux = DW'(aback_q);
      OFS_IRQ:     rd_mux[IRQ_EMPTY_BIT] = irq_q;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      shadow_q  <= '0;
      armed_q   <= 1'b0;
    end else begin
      if (rd_en) bus_rdata <= rd_mux;
      if (bus_sel) armed_q <= rd_en && bus_addr == OFS_PEND_HI;
      if (rd_en && bus_addr == OFS_PEND_HI) shadow_q <= pend_q;
    end
  end
endmodule

// File: rtl/tp_pick.sv
module tp_pick #(
  parameter int NMBX = 16,
  parameter int IDW  = 11,
  localparam int MBW = $clog2(NMBX)
) (
  input  logic [NMBX-1:0]     cand,
  input  logic [NMBX*IDW-1:0] ids_flat,
  input  logic                by_number,
  output logic                win_any,
  output logic [MBW-1:0]      win_mbx
);
  logic [IDW-1:0] id_arr [NMBX];

  for (genvar g = 0; g < NMBX; g++) begin : g_unpack
    assign id_arr[g] = ids_flat[g*IDW +: IDW];
  end

  logic [IDW-1:0] best_id;

  always_comb begin
    win_any = 1'b0;
    win_mbx = '0;
    best_id = '0;
    for (int m = 1; m < NMBX; m++) begin
      if (cand[m] && (!win_any || by_number || id_arr[m] <= best_id)) begin
        win_any = 1'b1;
        win_mbx = m[MBW-1:0];
        best_id = id_arr[m];
      end
    end
  end
endmodule

// File: rtl/tp_core.sv
module tp_core
  import tp_pkg::*;
#(
  parameter int NMBX = 16,
  localparam int MBW = $clog2(NMBX)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NMBX-1:0] set_req,
  input  logic [NMBX-1:0] cxl_req,
  input  logic [NMBX-1:0] aback_clr,
  input  logic            irq_clr,
  input  logic [NMBX-1:0] mbx_is_tx,
  input  logic [NMBX-1:0] mbx_no_retry,
  input  logic            eng_start,
  input  logic            eng_done,
  input  logic [1:0]      eng_result,
  input  logic            win_any,
  input  logic [MBW-1:0]  win_mbx,
  output logic [NMBX-1:0] eligible_d,
  output logic [NMBX-1:0] pend_q,
  output logic [NMBX-1:0] cxl_q,
  output logic [NMBX-1:0] aback_q,
  output logic            irq_q,
  output logic            busy_q,
  output logic [MBW-1:0]  cur_q,
  output logic            offer_valid,
  output logic [MBW-1:0]  offer_mbx
);
  localparam logic [NMBX-1:0] SLOT_MASK = ~NMBX'(1);

  logic [NMBX-1:0] pend_d, cxl_d, aback_d;
  logic            irq_d, busy_d;
  logic [MBW-1:0]  cur_d;

  always_comb begin
    pend_d  = pend_q;
    cxl_d   = cxl_q;
    aback_d = aback_q & ~aback_clr;
    irq_d   = irq_q && !irq_clr;
    busy_d  = busy_q;
    cur_d   = cur_q;

    if (!busy_q && eng_start && offer_valid) begin
      busy_d = 1'b1;
      cur_d  = offer_mbx;
    end

    if (busy_q && eng_done) begin
      busy_d = 1'b0;
      if (eng_result == RES_SENT) begin
        pend_d[cur_q] = 1'b0;
        cxl_d[cur_q]  = 1'b0;
        irq_d         = 1'b1;
      end else if (cxl_q[cur_q] || mbx_no_retry[cur_q]) begin
        pend_d[cur_q]  = 1'b0;
        cxl_d[cur_q]   = 1'b0;
        aback_d[cur_q] = 1'b1;
        irq_d          = 1'b1;
      end
    end

    for (int m = 1; m < NMBX; m++) begin
      if (cxl_q[m] && !(busy_q && cur_q == m[MBW-1:0])) begin
        pend_d[m]  = 1'b0;
        cxl_d[m]   = 1'b0;
        aback_d[m] = 1'b1;
        irq_d      = 1'b1;
      end
    end

    cxl_d  = cxl_d | (cxl_req & pend_q & SLOT_MASK);
    pend_d = pend_d | (set_req & mbx_is_tx & SLOT_MASK);
  end

  assign eligible_d = pend_d & ~cxl_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q      <= '0;
      cxl_q       <= '0;
      aback_q     <= '0;
      irq_q       <= 1'b0;
      busy_q      <= 1'b0;
      cur_q       <= '0;
      offer_valid <= 1'b0;
      offer_mbx   <= '0;
    end else begin
      pend_q      <= pend_d;
      cxl_q       <= cxl_d;
      aback_q     <= aback_d;
      irq_q       <= irq_d;
      busy_q      <= busy_d;
      cur_q       <= cur_d;
      offer_valid <= !busy_d && win_any;
      offer_mbx   <= win_mbx;
    end
  end
endmodule

// File: rtl/can_txpend.sv
module can_txpend
  import tp_pkg::*;
#(
  parameter int NMBX = 16,
  parameter int IDW  = 11,
  localparam int MBW = $clog2(NMBX)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [AW-1:0]       bus_addr,
  input  logic [DW-1:0]       bus_wdata,
  output logic [DW-1:0]       bus_rdata,
  input  logic                prio_by_number,
  input  logic [NMBX-1:0]     mbx_is_tx,
  input  logic [NMBX-1:0]     mbx_no_retry,
  input  logic [NMBX*IDW-1:0] mbx_id_flat,
  output logic                offer_valid,
  output logic [MBW-1:0]      offer_mbx,
  input  logic                eng_start,
  input  logic                eng_done,
  input  logic [1:0]          eng_result,
  output logic                irq_mbx_empty
);
  logic [NMBX-1:0] set_req, cxl_req, aback_clr, eligible_d;
  logic [NMBX-1:0] pend_q, cxl_q, aback_q;
  logic            irq_clr, irq_q, busy_q, win_any;
  logic [MBW-1:0]  cur_q, win_mbx;

  tp_bus #(.NMBX(NMBX)) u_bus (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .pend_q(pend_q), .cxl_q(cxl_q), .aback_q(aback_q), .irq_q(irq_q),
    .set_req(set_req), .cxl_req(cxl_req), .aback_clr(aback_clr),
    .irq_clr(irq_clr), .bus_rdata(bus_rdata)
  );

  tp_pick #(.NMBX(NMBX), .IDW(IDW)) u_pick (
    .cand(eligible_d), .ids_flat(mbx_id_flat), .by_number(prio_by_number),
    .win_any(win_any), .win_mbx(win_mbx)
  );

  tp_core #(.NMBX(NMBX)) u_core (
    .clk(clk), .rst(rst), .set_req(set_req), .cxl_req(cxl_req),
    .aback_clr(aback_clr), .irq_clr(irq_clr), .mbx_is_tx(mbx_is_tx),
    .mbx_no_retry(mbx_no_retry), .eng_start(eng_start), .eng_done(eng_done),
    .eng_result(eng_result), .win_any(win_any), .win_mbx(win_mbx),
    .eligible_d(eligible_d), .pend_q(pend_q), .cxl_q(cxl_q),
    .aback_q(aback_q), .irq_q(irq_q), .busy_q(busy_q), .cur_q(cur_q),
    .offer_valid(offer_valid), .offer_mbx(offer_mbx)
  );

  assign irq_mbx_empty = irq_q;
endmodule

// File: rtl/tp_checker.sv
module tp_checker
  import tp_pkg::*;
#(
  parameter int NMBX = 16,
  parameter int MBW  = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            bus_sel,
  input logic            bus_wr,
  input logic [AW-1:0]   bus_addr,
  input logic [DW-1:0]   bus_rdata,
  input logic [NMBX-1:0] mbx_is_tx,
  input logic [NMBX-1:0] mbx_no_retry,
  input logic            eng_done,
  input logic [1:0]      eng_result,
  input logic [NMBX-1:0] pend_q,
  input logic [NMBX-1:0] cxl_q,
  input logic            busy_q,
  input logic [MBW-1:0]  cur_q,
  input logic            offer_valid,
  input logic [MBW-1:0]  offer_mbx
);
  // R2: the upper request word always reads back as zero
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (rst)
    $past(bus_sel && !bus_wr && bus_addr == OFS_PEND_HI) |-> bus_rdata == '0);

  // R3: a request never rises for a mailbox that is not a transmitter
  a_r3_tx_only: assert property (@(posedge clk) disable iff (rst)
    !$stable(pend_q) |-> ((pend_q & ~$past(pend_q) & ~$past(mbx_is_tx)) == '0));

  // R4: a request drops only after an engine outcome or a waiting cancel
  a_r4_clear_cause: assert property (@(posedge clk) disable iff (rst)
    (|($past(pend_q) & ~pend_q)) |-> ($past(eng_done) || (|$past(cxl_q))));

  // R6: a failed attempt that may retry keeps its request
  a_r6_retry_keeps: assert property (@(posedge clk) disable iff (rst)
    $past(busy_q && eng_done && eng_result != 2'b00 &&
          !mbx_no_retry[cur_q] && !cxl_q[cur_q]) |-> pend_q[$past(cur_q)]);

  // R8: an offer always names a pending mailbox and never overlaps an attempt
  a_r8_offer_pending: assert property (@(posedge clk) disable iff (rst)
    offer_valid |-> (pend_q[offer_mbx] && !busy_q));
endmodule

bind can_txpend tp_checker #(.NMBX(NMBX), .MBW(MBW)) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .mbx_is_tx(mbx_is_tx),
  .mbx_no_retry(mbx_no_retry), .eng_done(eng_done), .eng_result(eng_result),
  .pend_q(pend_q), .cxl_q(cxl_q), .busy_q(busy_q), .cur_q(cur_q),
  .offer_valid(offer_valid), .offer_mbx(offer_mbx)
);

// File: tb/can_txpend_test.sv
module can_txpend_test;
  localparam int NMBX = 16;
  localparam int IDW  = 11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic              bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]        bus_addr = '0;
  logic [15:0]       bus_wdata = '0, bus_rdata;
  logic              prio_by_number = 1'b0;
  logic [NMBX-1:0]   mbx_is_tx = 16'hFFF7, mbx_no_retry = '0;
  logic [NMBX*IDW-1:0] mbx_id_flat;
  logic [IDW-1:0]    id_arr [NMBX];
  logic              offer_valid, eng_start = 1'b0, eng_done = 1'b0;
  logic [3:0]        offer_mbx;
  logic [1:0]        eng_result = 2'b00;
  logic              irq_mbx_empty;

  always_comb
    for (int m = 0; m < NMBX; m++) mbx_id_flat[m*IDW +: IDW] = id_arr[m];

  can_txpend uut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .prio_by_number(prio_by_number), .mbx_is_tx(mbx_is_tx),
    .mbx_no_retry(mbx_no_retry), .mbx_id_flat(mbx_id_flat),
    .offer_valid(offer_valid), .offer_mbx(offer_mbx),
    .eng_start(eng_start), .eng_done(eng_done), .eng_result(eng_result),
    .irq_mbx_empty(irq_mbx_empty)
  );

  int checks = 0, errors = 0;

  typedef struct { string tag; logic [15:0] val; } exp_t;
  exp_t exp_q[$];
  logic rd_seen = 1'b0;

  // monitor: a read sampled at an edge is compared at the following falling edge
  always @(posedge clk) rd_seen <= bus_sel && !bus_wr;
  always @(negedge clk) begin
    if (rd_seen) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: unexpected read, actual %h expected none", bus_rdata);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (bus_rdata !== e.val) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", e.tag, bus_rdata, e.val);
        end
      end
    end
  end

  task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, input logic [15:0] ev, input string tag);
    @(negedge clk);
    exp_q.push_back('{tag, ev});
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic check_bit(input logic act, input logic ev, input string tag);
    checks++;
    if (act !== ev) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, ev);
    end
  endtask

  task automatic check_offer(input logic [3:0] ev, input string tag);
    @(negedge clk); @(negedge clk);
    checks++;
    if (!(offer_valid === 1'b1 && offer_mbx === ev)) begin
      errors++;
      $display("FAIL %s: actual valid %b mbx %0d expected mbx %0d",
               tag, offer_valid, offer_mbx, ev);
    end
  endtask

  task automatic eng_go();
    @(negedge clk);
    eng_start = 1'b1;
    @(negedge clk);
    eng_start = 1'b0;
  endtask

  task automatic eng_finish(input logic [1:0] r);
    @(negedge clk);
    eng_done = 1'b1; eng_result = r;
    @(negedge clk);
    eng_done = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    settle();
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: actual %0d reads left expected 0", exp_q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int m = 0; m < NMBX; m++) id_arr[m] = 11'h400 + 11'(m);
    id_arr[1] = 11'd50; id_arr[2] = 11'd20; id_arr[5] = 11'd20; id_arr[7] = 11'd90;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // reset state
    bus_read(8'h22, 16'h0000, "R1 reset low word");
    bus_read(8'h20, 16'h0000, "R2 reset high word");
    check_bit(offer_valid, 1'b0, "R8 no offer after reset");
    check_bit(irq_mbx_empty, 1'b0, "R5 empty flag after reset");

    // R1 R3: bit0 and non-transmitter mailbox 3 ignored
    bus_write(8'h22, 16'h000F);
    bus_read(8'h22, 16'h0006, "R3 set only tx mailboxes, R1 bit0 stays 0");
    bus_write(8'h22, 16'h0000);
    bus_read(8'h22, 16'h0006, "R4 writing zero clears nothing");
    bus_write(8'h20, 16'hFFFF);
    bus_read(8'h20, 16'h0000, "R2 upper word write ignored");
    bus_read(8'h22, 16'h0006, "R2 upper write leaves lower word");

    // R8 R9 priority
    bus_write(8'h22, 16'h00A0);
    bus_read(8'h22, 16'h00A6, "R3 set mailboxes 5 and 7");
    check_offer(4'd5, "R8 lowest id, tie to higher mailbox");
    prio_by_number = 1'b1;
    check_offer(4'd7, "R9 highest mailbox number");
    prio_by_number = 1'b0;
    check_offer(4'd5, "R8 back to identifier order");

    // R5 success
    eng_go();
    check_bit(offer_valid, 1'b0, "R8 no offer while attempt open");
    eng_finish(2'b00);
    settle();
    bus_read(8'h22, 16'h0086, "R5 sent mailbox cleared");
    bus_read(8'h08, 16'h0100, "R5 empty flag raised");
    bus_read(8'h2A, 16'h0000, "R5 no abort acknowledge on success");
    bus_write(8'h08, 16'h0100);
    bus_read(8'h08, 16'h0000, "R13 empty flag cleared by write 1");

    // R6 retry
    check_offer(4'd2, "R8 next by identifier");
    eng_go();
    eng_finish(2'b01);
    bus_read(8'h22, 16'h0086, "R6 arbitration loss keeps request");
    check_offer(4'd2, "R6 reoffered after arbitration loss");
    eng_go();
    eng_finish(2'b10);
    bus_read(8'h22, 16'h0086, "R6 bus error keeps request");
    check_bit(irq_mbx_empty, 1'b0, "R6 no empty flag on retry");

    // R7 no retransmit
    mbx_no_retry[2] = 1'b1;
    check_offer(4'd2, "R6 reoffered after bus error");
    eng_go();
    eng_finish(2'b10);
    settle();
    bus_read(8'h22, 16'h0082, "R7 no-retry failure clears request");
    bus_read(8'h2A, 16'h0004, "R7 abort acknowledge set");
    check_bit(irq_mbx_empty, 1'b1, "R7 empty flag raised");
    bus_write(8'h2A, 16'h0004);
    bus_read(8'h2A, 16'h0000, "R13 abort acknowledge cleared by write 1");
    bus_write(8'h08, 16'h0100);
    mbx_no_retry[2] = 1'b0;

    // R10 idle cancel
    bus_write(8'h26, 16'h0002);
    settle();
    bus_read(8'h22, 16'h0080, "R10 idle cancel clears request");
    bus_read(8'h2A, 16'h0002, "R10 idle cancel acknowledged");
    check_bit(irq_mbx_empty, 1'b1, "R10 empty flag raised");
    bus_write(8'h26, 16'h0200);
    settle();
    bus_read(8'h26, 16'h0000, "R10 cancel of idle slot ignored");
    bus_read(8'h2A, 16'h0002, "R10 ignored cancel leaves acknowledge");
    bus_write(8'h2A, 16'h0002);
    bus_write(8'h08, 16'h0100);

    // R11 cancel in flight
    check_offer(4'd7, "R8 only mailbox 7 left");
    eng_go();
    bus_write(8'h26, 16'h0080);
    settle();
    bus_read(8'h26, 16'h0080, "R11 cancel held during attempt");
    bus_read(8'h22, 16'h0080, "R11 request kept during attempt");
    eng_finish(2'b00);
    settle();
    bus_read(8'h22, 16'h0000, "R11 success clears request");
    bus_read(8'h2A, 16'h0000, "R11 success gives no acknowledge");
    bus_read(8'h26, 16'h0000, "R11 cancel retired");
    bus_write(8'h22, 16'h0080);
    check_offer(4'd7, "R11 mailbox 7 offered again");
    eng_go();
    bus_write(8'h26, 16'h0080);
    eng_finish(2'b01);
    settle();
    bus_read(8'h22, 16'h0000, "R11 failed attempt with cancel clears");
    bus_read(8'h2A, 16'h0080, "R11 failed attempt with cancel acknowledged");
    bus_write(8'h2A, 16'h0080);
    bus_read(8'h2A, 16'h0000, "R13 acknowledge cleared");

    // R12 coherent longword read
    bus_write(8'h22, 16'h0006);
    check_offer(4'd2, "R12 setup offer");
    eng_go();
    @(negedge clk);
    exp_q.push_back('{"R2 upper word in longword read", 16'h0000});
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 8'h20;
    eng_done = 1'b1; eng_result = 2'b00;
    @(negedge clk);
    bus_sel = 1'b0; eng_done = 1'b0;
    bus_read(8'h22, 16'h0006, "R12 adjacent read returns captured word");
    bus_read(8'h22, 16'h0002, "R12 later read returns live word");
    bus_read(8'h20, 16'h0000, "R2 upper word again");
    bus_read(8'h2A, 16'h0000, "R13 acknowledge still clear");
    bus_read(8'h22, 16'h0002, "R12 non-adjacent read is live");

    finish_run();
  end
endmodule